// File: doc/BRIEF.md
# Multiport Vector Register File

This block holds sixteen 128-bit vector registers and serves three read ports and two write ports every cycle. The three read ports supply the operands of a fused multiply-add in one cycle. One write port takes results from the arithmetic path. The other takes data from a load that runs alongside computation.

Each write port has its own set of simple dual-port banks, with one copy of the set for each read port. Every bank takes one write and gives one read per cycle. A one-bit-per-register table in flip-flops records which write port last wrote each register. All bank reads and the table lookup happen in the same cycle. A final mux then picks, for each read port, the bank that the table names. Reads are synchronous. A read sees the contents as they stood before any write in the same cycle.

Top module: `vrf_top`

## Requirements
- R1: The file holds 16 registers of 128 bits. The three read ports take independent addresses, and any combination of addresses, including all three equal, is allowed in one cycle.
- R2: A write on the arithmetic port (aluWrEn high) stores aluWrData in register aluWrAddr. The value is returned by any read issued in a later cycle.
- R3: A write on the load port (ldWrEn high) stores ldWrData in register ldWrAddr. It may happen in the same cycle as an arithmetic write to another register, and both values are kept.
- R4: Read latency is one cycle. The data for the address presented before a rising clock edge appears on the read data port after that edge and holds until the next edge.
- R5: A read of a register that is written in the same cycle returns the value the register held before that cycle.
- R6: When both write ports target the same register in the same cycle, the load data is kept and later reads return it.
- R7: An arithmetic write to a register last written by the load port makes later reads return the arithmetic data, and the reverse also holds.
- R8: After reset, every register reads as zero and the read data ports are zero.
- R9: A register that no write port targets keeps its value, and the record of its newest write port does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| aluWrEn | input | 1 | Arithmetic result write enable |
| aluWrAddr | input | 4 | Arithmetic result write register |
| aluWrData | input | 128 | Arithmetic result write data |
| ldWrEn | input | 1 | Load write enable |
| ldWrAddr | input | 4 | Load write register |
| ldWrData | input | 128 | Load write data |
| rdAddr | input | 12 | Read addresses, port p at bits [4p+3:4p] |
| rdData | output | 384 | Read data, port p at bits [128p+127:128p] |

## Verification
Several properties are checked every cycle. The table must point at the load bank after any load write. It must point back at the arithmetic bank after an arithmetic write that does not collide with a load. It must stay unchanged in cycles with no writes. A register read one cycle after a load must return that load's data on every read port. The bench alone shows the full data path: the zero state after reset, the old value returned on a same-cycle read and write, the collision priority across all three ports, and long random traffic compared against a flat reference array.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int NUM_WR_PORTS = 2;
  localparam int ALU_BANK = 0;
  localparam int LD_BANK  = 1;

  typedef struct packed {
    logic aluWr;
    logic ldWr;
  } bankWrStrobe_t;
endpackage

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdData <= '0;
    end else begin
      rdData <= mem[rdAddr];
      if (wrEn) mem[wrAddr] <= wrData;
    end
  end
endmodule

// File: rtl/vrf_ctrl.sv
module vrf_ctrl
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_RD   = 3,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     aluWrEn,
  input  logic [ADDR_W-1:0]        aluWrAddr,
  input  logic                     ldWrEn,
  input  logic [ADDR_W-1:0]        ldWrAddr,
  input  logic [NUM_RD*ADDR_W-1:0] rdAddr,
  output bankWrStrobe_t            wrStrobe,
  output logic [NUM_RD-1:0]        rdSelQ
);
  // Bit set: the load bank holds the newest copy of that register.
  logic [NUM_REGS-1:0] newestLdQ;

  assign wrStrobe.aluWr = aluWrEn;
  assign wrStrobe.ldWr  = ldWrEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      newestLdQ <= '0;
    end else begin
      // The load update comes second so it wins a same-register collision.
      if (aluWrEn) newestLdQ[aluWrAddr] <= 1'b0;
      if (ldWrEn)  newestLdQ[ldWrAddr]  <= 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdSelQ[r] <= 1'b0;
      else        rdSelQ[r] <= newestLdQ[rdAddr[r*ADDR_W +: ADDR_W]];
    end
  end

  // R6: after any load write the table names the load bank.
  assert_ld_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ldWrEn |=> newestLdQ[$past(ldWrAddr)]);

  // R7: a non-colliding arithmetic write points the table back at its bank.
  assert_alu_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (aluWrEn && !(ldWrEn && ldWrAddr == aluWrAddr)) |=> !newestLdQ[$past(aluWrAddr)]);

  // R9: with no write at all the table stays put.
  assert_tbl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!aluWrEn && !ldWrEn) |=> $stable(newestLdQ));
endmodule

// File: rtl/vrf_datapath.sv
module vrf_datapath
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 128,
  parameter int NUM_RD   = 3,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bankWrStrobe_t            wrStrobe,
  input  logic [ADDR_W-1:0]        aluWrAddr,
  input  logic [DATA_W-1:0]        aluWrData,
  input  logic [ADDR_W-1:0]        ldWrAddr,
  input  logic [DATA_W-1:0]        ldWrData,
  input  logic [NUM_RD*ADDR_W-1:0] rdAddr,
  input  logic [NUM_RD-1:0]        rdSelQ,
  output logic [NUM_RD*DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bankQ [NUM_WR_PORTS][NUM_RD];

  for (genvar w = 0; w < NUM_WR_PORTS; w++) begin : g_wr
    logic              bankWe;
    logic [ADDR_W-1:0] bankWa;
    logic [DATA_W-1:0] bankWd;
    if (w == LD_BANK) begin : g_ld
      assign bankWe = wrStrobe.ldWr;
      assign bankWa = ldWrAddr;
      assign bankWd = ldWrData;
    end else begin : g_alu
      assign bankWe = wrStrobe.aluWr;
      assign bankWa = aluWrAddr;
      assign bankWd = aluWrData;
    end
    for (genvar r = 0; r < NUM_RD; r++) begin : g_copy
      vrf_bank #(.DEPTH(NUM_REGS), .DATA_W(DATA_W)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrEn   (bankWe),
        .wrAddr (bankWa),
        .wrData (bankWd),
        .rdAddr (rdAddr[r*ADDR_W +: ADDR_W]),
        .rdData (bankQ[w][r])
      );
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_mux
    assign rdData[r*DATA_W +: DATA_W] = rdSelQ[r] ? bankQ[LD_BANK][r] : bankQ[ALU_BANK][r];
  end
endmodule

// File: rtl/vrf_top.sv
module vrf_top
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 128,
  parameter int NUM_RD   = 3,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     aluWrEn,
  input  logic [ADDR_W-1:0]        aluWrAddr,
  input  logic [DATA_W-1:0]        aluWrData,
  input  logic                     ldWrEn,
  input  logic [ADDR_W-1:0]        ldWrAddr,
  input  logic [DATA_W-1:0]        ldWrData,
  input  logic [NUM_RD*ADDR_W-1:0] rdAddr,
  output logic [NUM_RD*DATA_W-1:0] rdData
);
  bankWrStrobe_t     wrStrobe;
  logic [NUM_RD-1:0] rdSelQ;

  vrf_ctrl #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .aluWrEn(aluWrEn), .aluWrAddr(aluWrAddr),
    .ldWrEn(ldWrEn), .ldWrAddr(ldWrAddr),
    .rdAddr(rdAddr), .wrStrobe(wrStrobe), .rdSelQ(rdSelQ)
  );

  vrf_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) dp_i (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe),
    .aluWrAddr(aluWrAddr), .aluWrData(aluWrData),
    .ldWrAddr(ldWrAddr), .ldWrData(ldWrData),
    .rdAddr(rdAddr), .rdSelQ(rdSelQ), .rdData(rdData)
  );

  // Counts edges since reset so the two-deep history below is all post-reset.
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_chk
    // R3: a register read in the cycle after a load returns the load data.
    assert_ld_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (warmCnt == 2'd2 && $past(ldWrEn, 2) &&
       $past(rdAddr[r*ADDR_W +: ADDR_W]) == $past(ldWrAddr, 2))
      |-> rdData[r*DATA_W +: DATA_W] == $past(ldWrData, 2));
  end
endmodule

// File: tb/vrf_top_tb_top.sv
module vrf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int DW   = 128;
  localparam int NRD  = 3;
  localparam int AW   = 4;

  typedef struct {
    logic [DW-1:0] exp [NRD];
    string         tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aluWrEn = 1'b0, ldWrEn = 1'b0;
  logic [AW-1:0] aluWrAddr = '0, ldWrAddr = '0;
  logic [DW-1:0] aluWrData = '0, ldWrData = '0;
  logic [NRD*AW-1:0] rdAddr = '0;
  logic [NRD*DW-1:0] rdData;

  logic [DW-1:0] refArr [NREG];
  item_t sbQ [$];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrf_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .aluWrEn(aluWrEn), .aluWrAddr(aluWrAddr), .aluWrData(aluWrData),
    .ldWrEn(ldWrEn), .ldWrAddr(ldWrAddr), .ldWrData(ldWrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [DW-1:0] mkData(int seed);
    return {4{32'(seed) ^ 32'h5a5a_0000}} ^ {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Driver: one vector per cycle, expected values taken from the reference
  // before this cycle's writes (R5), then the reference is updated (R6).
  task automatic drive(input logic ae, input int aa, input logic [DW-1:0] ad,
                       input logic le, input int la, input logic [DW-1:0] ld,
                       input int r0, input int r1, input int r2, input string tag);
    item_t it;
    int ra [NRD];
    @(negedge clk);
    ra[0] = r0; ra[1] = r1; ra[2] = r2;
    aluWrEn = ae; aluWrAddr = AW'(aa); aluWrData = ad;
    ldWrEn = le;  ldWrAddr = AW'(la);  ldWrData = ld;
    for (int p = 0; p < NRD; p++) begin
      rdAddr[p*AW +: AW] = AW'(ra[p]);
      it.exp[p] = refArr[ra[p]];
    end
    it.tag = tag;
    sbQ.push_back(it);
    if (ae) refArr[aa] = ad;
    if (le) refArr[la] = ld;
  endtask

  task automatic idle();
    drive(1'b0, 0, '0, 1'b0, 0, '0, 0, 1, 2, "R9");
  endtask

  // Monitor: results of the vector driven before an edge appear after it (R4).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() != 0) begin
        item_t it;
        it = sbQ.pop_front();
        for (int p = 0; p < NRD; p++) begin
          nChecks++;
          if (rdData[p*DW +: DW] !== it.exp[p]) begin
            nFails++;
            $display("FAIL %s port %0d actual %h expected %h", it.tag, p,
                     rdData[p*DW +: DW], it.exp[p]);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a, b;
    for (int i = 0; i < NREG; i++) refArr[i] = '0;
    repeat (3) @(negedge clk);
    // R8: outputs zero directly out of reset.
    nChecks++;
    if (rdData !== '0) begin
      nFails++;
      $display("FAIL R8 reset outputs actual %h expected 0", rdData);
    end
    rst_n = 1'b1;
    // R8: every register reads zero after reset.
    for (int i = 0; i < NREG; i += 3) drive(0, 0, '0, 0, 0, '0, i, (i+1)%NREG, (i+2)%NREG, "R8");
    // R2: arithmetic writes, then read back.
    for (int i = 0; i < NREG; i++) drive(1, i, mkData(i), 0, 0, '0, 0, 0, 0, "R2");
    for (int i = 0; i < NREG; i += 3) drive(0, 0, '0, 0, 0, '0, i, (i+1)%NREG, (i+2)%NREG, "R2");
    // R3: load and arithmetic writes in the same cycle to different registers.
    drive(1, 3, mkData(100), 1, 4, mkData(101), 0, 0, 0, "R3");
    drive(0, 0, '0, 0, 0, '0, 3, 4, 3, "R3");
    // R1: all three ports on one register, then three distinct.
    drive(0, 0, '0, 0, 0, '0, 4, 4, 4, "R1");
    drive(0, 0, '0, 0, 0, '0, 15, 0, 7, "R1");
    // R5: read of a register being written returns its old value.
    drive(1, 7, mkData(200), 1, 8, mkData(201), 7, 8, 7, "R5");
    drive(0, 0, '0, 0, 0, '0, 7, 8, 7, "R5");
    // R6: same-register collision, load wins.
    a = mkData(300); b = mkData(301);
    drive(1, 9, a, 1, 9, b, 9, 9, 9, "R6");
    drive(0, 0, '0, 0, 0, '0, 9, 9, 9, "R6");
    // R7: newest-writer flips load -> arithmetic -> load.
    drive(1, 9, mkData(400), 0, 0, '0, 0, 0, 0, "R7");
    drive(0, 0, '0, 0, 0, '0, 9, 9, 9, "R7");
    drive(0, 0, '0, 1, 9, mkData(401), 0, 0, 0, "R7");
    drive(0, 0, '0, 0, 0, '0, 9, 9, 9, "R7");
    // R9: idle cycles keep everything.
    repeat (4) idle();
    for (int i = 0; i < NREG; i += 3) drive(0, 0, '0, 0, 0, '0, i, (i+1)%NREG, (i+2)%NREG, "R9");
    // Random traffic on all five ports, narrowed addresses to force collisions.
    for (int n = 0; n < 3000; n++) begin
      int nar;
      nar = (n < 1500) ? 4 : NREG;
      drive(1'($urandom), int'($urandom % nar), mkData(n),
            1'($urandom), int'($urandom % nar), mkData(n + 7),
            int'($urandom % nar), int'($urandom % nar), int'($urandom % nar), "R6");
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule